// File: doc/BRIEF.md
# Relative Clock Speed Detector

This block measures which of two unrelated clocks, a write-side clock and a read-side clock, runs faster after a master reset. Each clock drives its own 10-bit counter. The counter starts when reset is released and counts 1024 edges of its own clock. Each counter's terminal-count flag crosses into a common reference clock domain, and the first flag to arrive there decides a single fast-clock bit. The bit is 1 when the write clock wins and 0 when the read clock wins.

Once the bit is decided, a host on the reference clock may overwrite it with a one-cycle write strobe. Any change of the bit, whether from the measurement or from a host write, starts a settle timer of 1024 reference cycles. A `settled` output tells downstream logic when reads and writes may proceed. The logic that consumes the bit is not part of this block. The measurement is only meaningful while the ratio of the two clock frequencies stays between 0.5 and 2.

Top module: `clk_race_detector`

## Requirements
- R1: While `rst_n` is low, and in the first reference cycle after it is released, `fast_wr` is 0 and `settled` is 0.
- R2: Each domain counter counts 1024 edges of its own clock, starting after its two-stage reset release. It then stops, and holds until the next reset.
- R3: When the write clock is faster, `fast_wr` becomes 1.
- R4: When the read clock is faster, `fast_wr` becomes 0.
- R5: When both terminal-count flags reach the reference domain in the same cycle, the tie resolves to `fast_wr` = 1.
- R6: `settled` rises only after the decision has been made and 1024 further reference cycles have elapsed. Once high, it falls only on a host write or a reset.
- R7: When `ovr_we` is 1 on a reference edge after the decision, `fast_wr` takes `ovr_val` on that edge and `settled` drops. `settled` then stays low for exactly 1024 reference cycles.
- R8: An `ovr_we` pulse before the decision has no effect: `fast_wr` stays 0.
- R9: After the decision, a terminal-count flag that arrives later does not change `fast_wr`. This holds during a settle wait that follows a host write and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the decision, host write and settle timer run on it |
| wr_clk | input | 1 | Write-side clock under measurement |
| rd_clk | input | 1 | Read-side clock under measurement |
| rst_n | input | 1 | Asynchronous active-low master reset for all three domains |
| ovr_we | input | 1 | Host write strobe for the fast-clock bit (reference domain) |
| ovr_val | input | 1 | Value written to the fast-clock bit when `ovr_we` is 1 |
| fast_wr | output | 1 | Fast-clock bit: 1 means write clock faster, 0 means read clock faster |
| settled | output | 1 | High once a decision exists and the settle wait has finished |

## Verification
Two of this block's events can collide in one reference cycle: the arrival of a terminal-count flag and a host write of the bit. The slower clock's flag can also land while a host-write settle wait is running. The bench forces an exact terminal-count collision by driving both measured clocks from one source, and judges that the tie yields 1. It issues a host write shortly after a decision with a 2:1 clock ratio, so the slower flag arrives during the settle count. The bench then checks that the written value survives and that the wait lasts exactly 1024 cycles.

// File: rtl/clk_race_pkg.sv
`timescale 1ns/1ps
package clk_race_pkg;
  localparam int DOM_WR  = 0;
  localparam int DOM_RD  = 1;
  localparam int NUM_DOM = 2;
  localparam int RST_STAGES = 2;
endpackage

// File: rtl/cr_rst_sync.sv
`timescale 1ns/1ps
module cr_rst_sync
  import clk_race_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [RST_STAGES-1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg <= '0;
    else         stg <= {stg[RST_STAGES-2:0], 1'b1};
  end

  assign srst_n = stg[RST_STAGES-1];
endmodule

// File: rtl/cr_bit_sync.sv
`timescale 1ns/1ps
module cr_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cr_tc_counter.sv
`timescale 1ns/1ps
module cr_tc_counter #(
  parameter int CNT_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tc_hit
);
  localparam logic [CNT_W-1:0] TC_VAL = '1;

  logic             srst_n;
  logic [CNT_W-1:0] cnt;

  cr_rst_sync u_rs (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt    <= '0;
      tc_hit <= 1'b0;
    end else if (!tc_hit) begin
      if (cnt == TC_VAL) tc_hit <= 1'b1;
      else               cnt    <= cnt + 1'b1;
    end
  end

  // R2
  tc_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    tc_hit |=> tc_hit);

  // R2
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!srst_n)
    tc_hit |=> $stable(cnt));

  // R2
  tc_at_end_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(tc_hit) |-> (cnt == TC_VAL));
endmodule

// File: rtl/cr_judge.sv
`timescale 1ns/1ps
module cr_judge #(
  parameter int SETTLE_CYC = 1024
) (
  input  logic clk,
  input  logic srst_n,
  input  logic wr_tc,
  input  logic rd_tc,
  input  logic ovr_we,
  input  logic ovr_val,
  output logic fast_wr,
  output logic settled
);
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SW-1:0] LAST = SW'(SETTLE_CYC - 1);

  logic          decided;
  logic          busy;
  logic [SW-1:0] wait_cnt;
  logic          first_hit;
  logic          take_ovr;

  assign first_hit = !decided && (wr_tc || rd_tc);
  assign take_ovr  = decided && ovr_we;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      decided  <= 1'b0;
      fast_wr  <= 1'b0;
      busy     <= 1'b0;
      wait_cnt <= '0;
    end else if (first_hit) begin
      decided  <= 1'b1;
      fast_wr  <= wr_tc;
      busy     <= 1'b1;
      wait_cnt <= '0;
    end else if (take_ovr) begin
      fast_wr  <= ovr_val;
      busy     <= 1'b1;
      wait_cnt <= '0;
    end else if (busy) begin
      if (wait_cnt == LAST) busy     <= 1'b0;
      else                  wait_cnt <= wait_cnt + 1'b1;
    end
  end

  assign settled = decided && !busy;

  // R7
  ovr_apply_chk: assert property (@(posedge clk) disable iff (!srst_n)
    take_ovr |=> (!settled && (fast_wr == $past(ovr_val))));

  // R8
  early_ovr_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!decided && ovr_we && !wr_tc && !rd_tc) |=> !fast_wr);

  // R9
  bit_keep_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (decided && !ovr_we) |=> $stable(fast_wr));

  // R6
  settled_keep_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (settled && !ovr_we) |=> settled);

  // R5
  tie_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!decided && wr_tc && rd_tc) |=> fast_wr);
endmodule

// File: rtl/clk_race_detector.sv
`timescale 1ns/1ps
module clk_race_detector
  import clk_race_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int SETTLE_CYC  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic ovr_we,
  input  logic ovr_val,
  output logic fast_wr,
  output logic settled
);
  logic [NUM_DOM-1:0] dom_clk;
  logic [NUM_DOM-1:0] tc_raw;
  logic [NUM_DOM-1:0] tc_ref;
  logic               ref_srst_n;

  assign dom_clk[DOM_WR] = wr_clk;
  assign dom_clk[DOM_RD] = rd_clk;

  cr_rst_sync u_ref_rs (
    .clk    (ref_clk),
    .arst_n (rst_n),
    .srst_n (ref_srst_n)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    cr_tc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (dom_clk[d]),
      .rst_n  (rst_n),
      .tc_hit (tc_raw[d])
    );
    cr_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (ref_clk),
      .rst_n (ref_srst_n),
      .d     (tc_raw[d]),
      .q     (tc_ref[d])
    );
  end

  cr_judge #(.SETTLE_CYC(SETTLE_CYC)) u_judge (
    .clk     (ref_clk),
    .srst_n  (ref_srst_n),
    .wr_tc   (tc_ref[DOM_WR]),
    .rd_tc   (tc_ref[DOM_RD]),
    .ovr_we  (ovr_we),
    .ovr_val (ovr_val),
    .fast_wr (fast_wr),
    .settled (settled)
  );
endmodule

// File: tb/test_clk_race_detector.sv
`timescale 1ns/1ps
module test_clk_race_detector;
  localparam int SETTLE = 1024;
  localparam int REF_NS = 8;

  logic ref_clk = 1'b0;
  logic wg = 1'b0, rg = 1'b0;
  int   wr_half = 5, rd_half = 8;
  logic tie_mode = 1'b0;
  logic wr_clk, rd_clk;
  logic rst_n = 1'b0, ovr_we = 1'b0, ovr_val = 1'b0;
  logic fast_wr, settled;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  longint t_rel;

  always #4 ref_clk = ~ref_clk;
  always #(wr_half) wg = ~wg;
  always #(rd_half) rg = ~rg;
  assign wr_clk = wg;
  assign rd_clk = tie_mode ? wg : rg;

  clk_race_detector i_clk_race_detector (
    .ref_clk (ref_clk), .wr_clk (wr_clk), .rd_clk (rd_clk), .rst_n (rst_n),
    .ovr_we (ovr_we), .ovr_val (ovr_val), .fast_wr (fast_wr), .settled (settled)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic do_reset(input int wh, input int rh, input bit tie);
    rst_n = 1'b0;
    wr_half = wh; rd_half = rh; tie_mode = tie;
    #100;
    check(fast_wr == 1'b0, "R1 fast_wr in reset", fast_wr, 0);
    check(settled == 1'b0, "R1 settled in reset", settled, 0);
    @(negedge ref_clk); #1;
    rst_n = 1'b1;
    t_rel = $time;
    @(negedge ref_clk); #1;
    check(fast_wr == 1'b0, "R1 fast_wr after release", fast_wr, 0);
    check(settled == 1'b0, "R1 settled after release", settled, 0);
  endtask

  task automatic wait_settled(input int fast_ns);
    longint lo, hi, el;
    int n = 0;
    while (!settled && n < 40000) begin
      @(negedge ref_clk); #1;
      n++;
    end
    el = $time - t_rel;
    lo = 1024 * fast_ns + SETTLE * REF_NS;
    hi = 1027 * fast_ns + (SETTLE + 6) * REF_NS;
    check(el >= lo, "R2 R6 settle too early", el, lo);
    check(el <= hi, "R2 R6 settle too late", el, hi);
  endtask

  task automatic t_wr_faster();
    do_reset(5, 8, 1'b0);
    wait_settled(10);
    check(fast_wr == 1'b1, "R3 write clock faster", fast_wr, 1);
  endtask

  task automatic t_rd_faster();
    do_reset(8, 5, 1'b0);
    repeat (3) @(negedge ref_clk);
    ovr_we = 1'b1; ovr_val = 1'b1;
    @(negedge ref_clk);
    ovr_we = 1'b0;
    #1;
    check(fast_wr == 1'b0, "R8 early write ignored (bit)", fast_wr, 0);
    check(settled == 1'b0, "R8 early write ignored (settled)", settled, 0);
    wait_settled(10);
    check(fast_wr == 1'b0, "R4 read clock faster", fast_wr, 0);
  endtask

  task automatic t_tie();
    do_reset(5, 5, 1'b1);
    wait_settled(10);
    check(fast_wr == 1'b1, "R5 tie resolves to write", fast_wr, 1);
  endtask

  task automatic t_override();
    int n;
    do_reset(4, 8, 1'b0);
    #9000;
    @(negedge ref_clk); #1;
    check(fast_wr == 1'b1, "R3 decided before write", fast_wr, 1);
    ovr_we = 1'b1; ovr_val = 1'b0;
    @(negedge ref_clk);
    ovr_we = 1'b0;
    #1;
    check(fast_wr == 1'b0, "R7 bit takes written value", fast_wr, 0);
    check(settled == 1'b0, "R7 settled drops", settled, 0);
    n = 0;
    while (!settled && n < 5000) begin
      n++;
      @(negedge ref_clk); #1;
    end
    check(n == SETTLE, "R7 settle length after write", n, SETTLE);
    check(fast_wr == 1'b0, "R9 late count ignored", fast_wr, 0);
    #2000;
    @(negedge ref_clk); #1;
    check(fast_wr == 1'b0, "R9 bit still held", fast_wr, 0);
    check(settled == 1'b1, "R2 R6 no second decision", settled, 1);
    ovr_we = 1'b1; ovr_val = 1'b1;
    @(negedge ref_clk);
    ovr_we = 1'b0;
    #1;
    check(fast_wr == 1'b1, "R7 second write", fast_wr, 1);
    check(settled == 1'b0, "R7 settled drops again", settled, 0);
  endtask

  initial begin
    t_wr_faster();
    t_rd_faster();
    t_tie();
    t_override();
    do_reset(5, 8, 1'b0);
    done = 1'b1;
    finish_run();
  end
endmodule